// File: doc/BRIEF.md
# Sixteen-Channel Peripheral DMA Controller

This block moves data between peripherals and memory on behalf of sixteen independent channels. A peripheral raises a level request on its channel. Each request that the controller grants moves exactly one data unit: the controller reads one word from the channel's source address and then writes it to the channel's destination address. For those two bus cycles the controller holds the CPU in a stall. Each channel keeps a small descriptor: a 16-bit source address, a 16-bit destination address, a 16-bit unit count, and two flags that choose whether each address steps by one after every unit.

Software sets up and watches the channels through a byte-wide register port. That port holds two enable bytes and two completion bytes. It also holds one stop-status byte, which is banked so that it covers all sixteen channels. A channel-select register picks the visible stop bank and the channel whose descriptor appears in a descriptor window. A channel finishes in one of two ways. It can drain its count, which sets a completion flag and raises the interrupt. Or its peripheral can abort it with a stop request, which sets a separate stop-status bit.

Top module: `dma_ctrl`

## Requirements
- R1: After reset the following all read 0: every register, `irq_o`, `cpu_hold_o`, `mem_req_o` and `dack_o`.
- R2: Register byte map: 0xAD holds the enables for channels 15..8 and 0xAC those for 7..0. 0x9D holds the completion flags for 15..8 and 0x9C those for 7..0. In each byte, bit i belongs to the channel 8*half+i. 0x9B is the channel-select register, with the channel number in bits 3..0 and the bank bit in bit 7. Bits 6..4 of 0x9B read 0.
- R3: Address 0xA4 reads and writes the stop status of channels 7..0 when the bank bit is 0, and that of channels 15..8 when it is 1.
- R4: The descriptor of the selected channel is exposed at these addresses: 0xB0/0xB1 source low/high byte, 0xB2/0xB3 destination low/high byte, 0xB4/0xB5 count low/high byte, and 0xB6 with bit0 = source increment and bit1 = destination increment. A readback shows the live values.
- R5: A granted unit takes one read cycle and then one write cycle. In the read cycle `mem_req_o`=1, `mem_we_o`=0 and the address is the source. In the write cycle `mem_we_o`=1, the address is the destination and the data is the word just read. `dack_o` is one-hot for the channel during the write cycle. `cpu_hold_o` is high in both cycles.
- R6: After each unit the source address steps by +1 if its flag is set and otherwise stays put. The destination address behaves the same way under its own flag. Both wrap modulo 2^16.
- R7: Each unit decrements the count. The unit that brings the count to 0 clears the channel's enable bit and sets its completion flag.
- R8: When several enabled channels request in the same idle cycle, the channel with the lowest number is served first.
- R9: If an enabled channel that is not moving a unit sees its stop input high, its enable clears and its stop-status bit sets, and no unit is moved for it. Disabled channels ignore requests.
- R10: `irq_o` is the OR of all completion flags. It stays high until software writes those flags to 0.
- R11: When a hardware update and a software write to the same register land in the same cycle, the hardware update wins. This covers a completion or stop bit being set and an enable bit being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| dreq_i | input | 16 | Per-channel transfer request (level) |
| stop_i | input | 16 | Per-channel stop request |
| dack_o | output | 16 | Per-channel unit acknowledge |
| mem_req_o | output | 1 | Bus cycle active |
| mem_we_o | output | 1 | Bus cycle is a write |
| mem_addr_o | output | 16 | Bus address |
| mem_wdata_o | output | DW | Bus write data |
| mem_rdata_i | input | DW | Bus read data, valid in the read cycle |
| cpu_hold_o | output | 1 | CPU stall |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two functions can fall in the same cycle: the hardware setting of a flag and the clearing of an enable when a channel ends, and a software write to the very same register byte. The bench provokes this by issuing a register write of zero to the completion byte during the write cycle of a channel's last unit. It then judges that the flag reads 1 afterwards. It does the same for a stop request that arrives while software writes the enable byte, and checks that the enable reads 0 and the stop bit reads 1. Random descriptors cover the address step options and the 16-bit wrap.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH = 16;
  localparam int CHW = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;

  localparam logic [7:0] A_EN_HI   = 8'hAD;
  localparam logic [7:0] A_EN_LO   = 8'hAC;
  localparam logic [7:0] A_STOP    = 8'hA4;
  localparam logic [7:0] A_DONE_HI = 8'h9D;
  localparam logic [7:0] A_DONE_LO = 8'h9C;
  localparam logic [7:0] A_CSEL    = 8'h9B;
  localparam logic [7:0] A_SRC_LO  = 8'hB0;
  localparam logic [7:0] A_SRC_HI  = 8'hB1;
  localparam logic [7:0] A_DST_LO  = 8'hB2;
  localparam logic [7:0] A_DST_HI  = 8'hB3;
  localparam logic [7:0] A_CNT_LO  = 8'hB4;
  localparam logic [7:0] A_CNT_HI  = 8'hB5;
  localparam logic [7:0] A_CTRL    = 8'hB6;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_e;
endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [CHW-1:0] start_ch_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           busy_o,
  output logic [CHW-1:0] act_ch_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           fin_o,
  output logic [NCH-1:0] dack_o
);
  eng_state_e     state_q;
  logic [CHW-1:0] ch_q;
  logic [DW-1:0]  buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      buf_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RD;
          ch_q    <= start_ch_i;
        end
        ST_RD: begin
          buf_q   <= mem_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign act_ch_o    = ch_q;
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = mem_we_o ? dst_i : src_i;
  assign mem_wdata_o = buf_q;
  assign fin_o       = mem_we_o;

  for (genvar g = 0; g < NCH; g++) begin : g_dack
    assign dack_o[g] = fin_o && (ch_q == CHW'(g));
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [7:0]     reg_addr_i,
  input  logic [7:0]     reg_wdata_i,
  output logic [7:0]     reg_rdata_o,
  input  logic [NCH-1:0] stop_i,
  input  logic           busy_i,
  input  logic [CHW-1:0] act_ch_i,
  input  logic           fin_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] done_o,
  output logic [AW-1:0]  src_act_o,
  output logic [AW-1:0]  dst_act_o
);
  logic [NCH-1:0] en_q, stp_q, done_q;
  logic [NCH-1:0] en_sw, stp_sw, done_sw;
  logic [NCH-1:0] act_oh, stop_hit, fin_oh;
  logic [7:0]     csel_q;
  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic           sinc_q [NCH];
  logic           dinc_q [NCH];
  logic [CHW-1:0] sel;
  logic           bank;
  logic           wr_en_hi, wr_en_lo, wr_stop, wr_dn_hi, wr_dn_lo;

  assign sel  = csel_q[CHW-1:0];
  assign bank = csel_q[7];

  assign wr_en_hi = reg_we_i && reg_addr_i == A_EN_HI;
  assign wr_en_lo = reg_we_i && reg_addr_i == A_EN_LO;
  assign wr_stop  = reg_we_i && reg_addr_i == A_STOP;
  assign wr_dn_hi = reg_we_i && reg_addr_i == A_DONE_HI;
  assign wr_dn_lo = reg_we_i && reg_addr_i == A_DONE_LO;

  always_comb begin
    en_sw   = en_q;
    stp_sw  = stp_q;
    done_sw = done_q;
    if (wr_en_hi) en_sw[15:8] = reg_wdata_i;
    if (wr_en_lo) en_sw[7:0]  = reg_wdata_i;
    if (wr_stop && bank)  stp_sw[15:8] = reg_wdata_i;
    if (wr_stop && !bank) stp_sw[7:0]  = reg_wdata_i;
    if (wr_dn_hi) done_sw[15:8] = reg_wdata_i;
    if (wr_dn_lo) done_sw[7:0]  = reg_wdata_i;
  end

  // the channel moving a unit finishes it before a stop is honoured
  assign act_oh   = busy_i ? (NCH'(1) << act_ch_i) : '0;
  assign stop_hit = stop_i & en_q & ~act_oh;
  assign fin_oh   = (fin_i && cnt_q[act_ch_i] == CW'(1)) ? (NCH'(1) << act_ch_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stp_q  <= '0;
      done_q <= '0;
      csel_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        cnt_q[i]  <= '0;
        sinc_q[i] <= 1'b0;
        dinc_q[i] <= 1'b0;
      end
    end else begin
      // hardware terms applied last so they win over a same-cycle write
      en_q   <= en_sw & ~stop_hit & ~fin_oh;
      stp_q  <= stp_sw | stop_hit;
      done_q <= done_sw | fin_oh;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          A_CSEL:   csel_q <= {reg_wdata_i[7], 3'b000, reg_wdata_i[3:0]};
          A_SRC_LO: src_q[sel][7:0]  <= reg_wdata_i;
          A_SRC_HI: src_q[sel][15:8] <= reg_wdata_i;
          A_DST_LO: dst_q[sel][7:0]  <= reg_wdata_i;
          A_DST_HI: dst_q[sel][15:8] <= reg_wdata_i;
          A_CNT_LO: cnt_q[sel][7:0]  <= reg_wdata_i;
          A_CNT_HI: cnt_q[sel][15:8] <= reg_wdata_i;
          A_CTRL: begin
            sinc_q[sel] <= reg_wdata_i[0];
            dinc_q[sel] <= reg_wdata_i[1];
          end
          default: ;
        endcase
      end
      if (fin_i) begin
        cnt_q[act_ch_i] <= cnt_q[act_ch_i] - CW'(1);
        if (sinc_q[act_ch_i]) src_q[act_ch_i] <= src_q[act_ch_i] + AW'(1);
        if (dinc_q[act_ch_i]) dst_q[act_ch_i] <= dst_q[act_ch_i] + AW'(1);
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_EN_HI:   reg_rdata_o = en_q[15:8];
      A_EN_LO:   reg_rdata_o = en_q[7:0];
      A_STOP:    reg_rdata_o = bank ? stp_q[15:8] : stp_q[7:0];
      A_DONE_HI: reg_rdata_o = done_q[15:8];
      A_DONE_LO: reg_rdata_o = done_q[7:0];
      A_CSEL:    reg_rdata_o = csel_q;
      A_SRC_LO:  reg_rdata_o = src_q[sel][7:0];
      A_SRC_HI:  reg_rdata_o = src_q[sel][15:8];
      A_DST_LO:  reg_rdata_o = dst_q[sel][7:0];
      A_DST_HI:  reg_rdata_o = dst_q[sel][15:8];
      A_CNT_LO:  reg_rdata_o = cnt_q[sel][7:0];
      A_CNT_HI:  reg_rdata_o = cnt_q[sel][15:8];
      A_CTRL:    reg_rdata_o = {6'b0, dinc_q[sel], sinc_q[sel]};
      default:   reg_rdata_o = 8'h00;
    endcase
  end

  assign en_o      = en_q;
  assign done_o    = done_q;
  assign src_act_o = src_q[act_ch_i];
  assign dst_act_o = dst_q[act_ch_i];
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [7:0]     reg_addr_i,
  input  logic [7:0]     reg_wdata_i,
  output logic [7:0]     reg_rdata_o,
  input  logic [NCH-1:0] dreq_i,
  input  logic [NCH-1:0] stop_i,
  output logic [NCH-1:0] dack_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           cpu_hold_o,
  output logic           irq_o
);
  logic [NCH-1:0] en_w, done_w, arb_req;
  logic           busy, fin, arb_valid;
  logic [CHW-1:0] act_ch, arb_idx;
  logic [AW-1:0]  src_act, dst_act;

  assign arb_req = en_w & dreq_i & ~stop_i & {NCH{~busy}};

  dma_arbiter #(.N(NCH)) i_arb (
    .req_i   (arb_req),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  dma_engine #(.DW(DW)) i_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (arb_valid),
    .start_ch_i  (arb_idx),
    .src_i       (src_act),
    .dst_i       (dst_act),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy),
    .act_ch_o    (act_ch),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .fin_o       (fin),
    .dack_o      (dack_o)
  );

  dma_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .stop_i      (stop_i),
    .busy_i      (busy),
    .act_ch_i    (act_ch),
    .fin_i       (fin),
    .en_o        (en_w),
    .done_o      (done_w),
    .src_act_o   (src_act),
    .dst_act_o   (dst_act)
  );

  assign cpu_hold_o = busy;
  assign irq_o      = |done_w;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk
  import dma_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_we_i,
  input logic [NCH-1:0] stop_i,
  input logic [NCH-1:0] dack_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic           cpu_hold_o,
  input logic           irq_o,
  input logic [NCH-1:0] en_w
);
  // R5
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |=> mem_req_o && mem_we_o);
  // R5
  hold_during_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cpu_hold_o);
  // R5
  dack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o) && (|dack_o -> mem_we_o));
  // R9
  stop_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_hold_o && |(stop_i & en_w) |=> (en_w & $past(stop_i)) == '0);
  // R10
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !reg_we_i |=> irq_o);
  // R10
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|dack_o) || $past(reg_we_i));
endmodule

bind dma_ctrl dma_ctrl_chk i_dma_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .stop_i     (stop_i),
  .dack_o     (dack_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .cpu_hold_o (cpu_hold_o),
  .irq_o      (irq_o),
  .en_w       (en_w)
);

// File: tb/test_dma_ctrl.sv
`timescale 1ns/1ps
module test_dma_ctrl;
  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] dreq = '0;
  logic [15:0] stop = '0;
  logic [15:0] dack;
  logic        mem_req, mem_we, cpu_hold, irq;
  logic [15:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] mem_model(input logic [15:0] a);
    return DW'(a ^ 16'h5A3C);
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  dma_ctrl #(.DW(DW)) i_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .dreq_i(dreq), .stop_i(stop), .dack_o(dack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .cpu_hold_o(cpu_hold), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_en(input int ch, input bit v);
    logic [7:0] b;
    logic [7:0] a;
    a = (ch >= 8) ? 8'hAD : 8'hAC;
    rd(a, b);
    b[ch % 8] = v;
    wr(a, b);
  endtask

  task automatic prog(input int ch, input logic [15:0] s, input logic [15:0] d,
                      input logic [15:0] n, input logic [1:0] ctl);
    wr(8'h9B, 8'(ch));
    wr(8'hB0, s[7:0]); wr(8'hB1, s[15:8]);
    wr(8'hB2, d[7:0]); wr(8'hB3, d[15:8]);
    wr(8'hB4, n[7:0]); wr(8'hB5, n[15:8]);
    wr(8'hB6, {6'b0, ctl});
  endtask

  task automatic run_xfer(input int ch, input logic [15:0] s, input logic [15:0] d,
                          input int n, input logic [1:0] ctl);
    logic [15:0] cs, cd;
    logic [7:0] b, lo, hi;
    int units, guard;
    cs = s; cd = d; units = 0; guard = 0;
    prog(ch, s, d, 16'(n), ctl);
    set_en(ch, 1'b1);
    @(negedge clk);
    dreq[ch] = 1'b1;
    while (units < n && guard < 40 * n + 10) begin
      @(negedge clk);
      guard++;
      if (mem_req && !mem_we) begin
        // R5 read phase at source with CPU stalled
        chk(mem_addr == cs && cpu_hold, "R5 read addr", mem_addr, cs);
      end else if (mem_req && mem_we) begin
        // R5 R6 write phase
        chk(mem_addr == cd, "R6 dst addr", mem_addr, cd);
        chk(mem_wdata == mem_model(cs), "R5 write data", mem_wdata, mem_model(cs));
        chk(dack == (16'h1 << ch), "R5 dack", dack, 16'h1 << ch);
        if (ctl[0]) cs = cs + 16'd1;
        if (ctl[1]) cd = cd + 16'd1;
        units++;
        if (units == n) dreq[ch] = 1'b0;
      end
    end
    dreq[ch] = 1'b0;
    chk(units == n, "R7 unit count", units, n);
    @(negedge clk);
    rd((ch >= 8) ? 8'h9D : 8'h9C, b);
    chk(b[ch % 8] == 1'b1, "R7 done flag", b, 8'h1 << (ch % 8));
    rd((ch >= 8) ? 8'hAD : 8'hAC, b);
    chk(b[ch % 8] == 1'b0, "R7 enable cleared", b, 0);
    chk(irq == 1'b1, "R10 irq set", irq, 1);
    rd(8'hB0, lo); rd(8'hB1, hi);
    chk({hi, lo} == cs, "R6 final src", {hi, lo}, cs);
    rd(8'hB2, lo); rd(8'hB3, hi);
    chk({hi, lo} == cd, "R6 final dst", {hi, lo}, cd);
    rd(8'hB4, lo); rd(8'hB5, hi);
    chk({hi, lo} == 16'h0, "R7 count zero", {hi, lo}, 0);
    wr((ch >= 8) ? 8'h9D : 8'h9C, 8'h00);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int first_rd, second_rd, seen;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (b[i]) ;
    rd(8'hAD, b); chk(b == 0, "R1 en hi", b, 0);
    rd(8'hAC, b); chk(b == 0, "R1 en lo", b, 0);
    rd(8'hA4, b); chk(b == 0, "R1 stop", b, 0);
    rd(8'h9D, b); chk(b == 0, "R1 done hi", b, 0);
    rd(8'h9C, b); chk(b == 0, "R1 done lo", b, 0);
    rd(8'h9B, b); chk(b == 0, "R1 csel", b, 0);
    rd(8'hB4, b); chk(b == 0, "R1 count", b, 0);
    chk(!irq && !cpu_hold && !mem_req && dack == 0, "R1 outputs", {irq, cpu_hold, mem_req}, 0);

    // R2 csel reserved bits
    wr(8'h9B, 8'hFF); rd(8'h9B, b);
    chk(b == 8'h8F, "R2 csel reserved", b, 8'h8F);
    // R3 stop banks
    wr(8'hA4, 8'h34);
    wr(8'h9B, 8'h00); wr(8'hA4, 8'h12);
    rd(8'hA4, b); chk(b == 8'h12, "R3 stop low bank", b, 8'h12);
    wr(8'h9B, 8'h80); rd(8'hA4, b);
    chk(b == 8'h34, "R3 stop high bank", b, 8'h34);
    wr(8'hA4, 8'h00); wr(8'h9B, 8'h00); wr(8'hA4, 8'h00);
    // R2 enable byte mapping
    wr(8'hAD, 8'h81); rd(8'hAD, b); chk(b == 8'h81, "R2 en hi rw", b, 8'h81);
    wr(8'hAD, 8'h00);

    // R4 descriptor window, R6 wrap
    prog(6, 16'h1234, 16'hABCD, 16'h0302, 2'b10);
    rd(8'hB1, b); chk(b == 8'h12, "R4 src hi", b, 8'h12);
    rd(8'hB2, b); chk(b == 8'hCD, "R4 dst lo", b, 8'hCD);
    rd(8'hB5, b); chk(b == 8'h03, "R4 count hi", b, 8'h03);
    rd(8'hB6, b); chk(b == 8'h02, "R4 ctrl", b, 8'h02);
    run_xfer(5, 16'hFFFF, 16'h8000, 3, 2'b11);
    run_xfer(15, 16'h0100, 16'h0200, 2, 2'b00);

    // random descriptors
    for (int k = 0; k < 14; k++) begin
      int ch, n;
      logic [1:0] ctl;
      ch  = int'($urandom_range(15, 0));
      n   = int'($urandom_range(5, 1));
      ctl = 2'($urandom_range(3, 0));
      run_xfer(ch, 16'($urandom), 16'($urandom), n, ctl);
    end

    // R8 fixed priority
    prog(9, 16'h0900, 16'h1900, 16'd1, 2'b00);
    prog(3, 16'h0300, 16'h1300, 16'd1, 2'b00);
    set_en(9, 1'b1); set_en(3, 1'b1);
    @(negedge clk);
    dreq[9] = 1'b1; dreq[3] = 1'b1;
    first_rd = -1; second_rd = -1; seen = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (mem_req && !mem_we) begin
        if (seen == 0) first_rd = int'(mem_addr); else second_rd = int'(mem_addr);
        seen++;
      end
    end
    dreq = '0;
    chk(first_rd == 32'h0300, "R8 lowest first", first_rd, 32'h0300);
    chk(second_rd == 32'h0900, "R8 next served", second_rd, 32'h0900);
    wr(8'h9C, 8'h00); wr(8'h9D, 8'h00);

    // R9 stop on idle channel, stop wins over request
    prog(10, 16'h0A00, 16'h1A00, 16'd4, 2'b11);
    set_en(10, 1'b1);
    @(negedge clk);
    stop[10] = 1'b1; dreq[10] = 1'b1;
    seen = 0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (mem_req) seen++;
    end
    stop[10] = 1'b0; dreq[10] = 1'b0;
    chk(seen == 0, "R9 no unit moved", seen, 0);
    rd(8'hAD, b); chk(b[2] == 1'b0, "R9 enable cleared", b, 0);
    wr(8'h9B, 8'h80); rd(8'hA4, b);
    chk(b == 8'h04, "R9 stop bit high bank", b, 8'h04);
    wr(8'h9B, 8'h00); rd(8'hA4, b);
    chk(b == 8'h00, "R9 low bank untouched", b, 0);
    // R9 disabled channel ignores request
    @(negedge clk); dreq[10] = 1'b1;
    seen = 0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (mem_req) seen++;
    end
    dreq[10] = 1'b0;
    chk(seen == 0, "R9 disabled ignores dreq", seen, 0);
    wr(8'h9B, 8'h80); wr(8'hA4, 8'h00); wr(8'h9B, 8'h00);

    // R11 done set vs software clear in the same cycle
    prog(1, 16'h0011, 16'h0022, 16'd1, 2'b00);
    set_en(1, 1'b1);
    @(negedge clk); dreq[1] = 1'b1;
    for (int t = 0; t < 10 && !(mem_req && mem_we); t++) @(negedge clk);
    dreq[1] = 1'b0;
    reg_we = 1'b1; reg_addr = 8'h9C; reg_wdata = 8'h00;
    @(negedge clk); reg_we = 1'b0;
    rd(8'h9C, b); chk(b == 8'h02, "R11 done beats write", b, 8'h02);
    wr(8'h9C, 8'h00);

    // R11 stop clear vs software enable write in the same cycle
    set_en(4, 1'b1);
    @(negedge clk);
    stop[4] = 1'b1;
    reg_we = 1'b1; reg_addr = 8'hAC; reg_wdata = 8'h10;
    @(negedge clk);
    reg_we = 1'b0; stop[4] = 1'b0;
    rd(8'hAC, b); chk(b == 8'h00, "R11 enable clear wins", b, 0);
    rd(8'hA4, b); chk(b == 8'h10, "R11 stop bit set", b, 8'h10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule